// File: doc/BRIEF.md
# Two-Processor Coherence Miss Classifier

This block models one multi-word cache block as it is seen by the private caches of two processors under an invalidation-based snooping protocol. Each clock it can take one access, given as a processor number, a read or write flag and a word index. It moves both cache copies through an Invalid / Shared / Modified state machine. One cycle later it reports whether that access hit, took a true sharing miss or took a false sharing miss.

Validity is kept as a single bit per cache copy. Alongside it, each processor keeps a per-word vector that records which words the other processor has written since this processor's copy was last fetched. A miss on a word set in that vector would also have happened with one-word blocks, so it is a true sharing miss. A miss on a word not set in that vector comes only from block granularity, so it is a false sharing miss. Performance models and coherence studies can use the block to attribute the cost of invalidations.

Top module: `coh_miss_classifier`

## Requirements
- R1: After reset both copies are Shared (state code 2'b01) with empty written-word vectors, so a read of any word by either processor reports hit (result code 2'b00).
- R2: `res_valid` is high in exactly the cycle after a cycle with `acc_valid` high, and `res_code` then gives the result of that access. Back-to-back accesses each produce one result, in order.
- R3: A read by a processor whose copy is Shared or Modified reports hit and changes no state.
- R4: A write by a processor whose copy is Modified (state code 2'b10) reports hit. The word it writes is marked in the other processor's written-word vector.
- R5: A write by a processor whose copy is Shared reports a true sharing miss (code 2'b01). The writer becomes Modified, and the other copy becomes Invalid (code 2'b00) with a vector holding only the written word.
- R6: A read by a processor whose copy is Invalid reports true sharing (2'b01) if the accessed word is set in its vector, and false sharing (2'b10) otherwise. The reader then becomes Shared with a cleared vector, and a Modified owner drops to Shared.
- R7: A write by a processor whose copy is Invalid is classified as in R6. The writer becomes Modified with a cleared vector, and the other copy becomes Invalid.
- R8: A Modified copy is never accompanied by a valid copy in the other cache.
- R9: The result code never takes the value 2'b11. Cycles without an access produce no result and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_cpu | input | 1 | Issuing processor (0 or 1) |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | $clog2(WORDS) | Word index inside the block |
| res_valid | output | 1 | Result strobe, one cycle after the access |
| res_code | output | 2 | 00 hit, 01 true sharing miss, 10 false sharing miss |

## Verification
Properties checked on every cycle: the one-cycle result latency, the legal result codes, the single-owner rule, hits for owner writes and valid reads, the true sharing code on upgrades, the cleared vector after a refetch, and the absence of state change when no access is presented. The choice between true and false sharing depends on the history of writes to words other than the one accessed, and only the bench's scripted sequences show it. These sequences cover words written before and after an invalidation, a downgrade of an owner by a reader, and the highest word index.

// File: rtl/coh_pkg.sv
// Shared types for the coherence miss classifier.
// Assumes exactly two processors share the modelled block.
package coh_pkg;
    localparam int NCPU = 2;

    typedef enum logic [1:0] {
        ST_INV = 2'b00,
        ST_SHR = 2'b01,
        ST_MOD = 2'b10
    } line_st_t;

    typedef enum logic [1:0] {
        RC_HIT   = 2'b00,
        RC_TRUE  = 2'b01,
        RC_FALSE = 2'b10
    } res_code_t;
endpackage

// File: rtl/mc_line_slot.sv
// One processor's copy of the block: its line state and its per-word
// record of words written by the other processor since the last fetch.
// Assumes the next values are computed outside and applied on upd.
module mc_line_slot
    import coh_pkg::*;
#(
    parameter int WORDS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  line_st_t         nxt_st,
    input  logic [WORDS-1:0] nxt_wbo,
    output line_st_t         st,
    output logic [WORDS-1:0] wbo
);
    // Hold state; reset to Shared with nothing recorded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_SHR;
            wbo <= '0;
        end else if (upd) begin
            st  <= nxt_st;
            wbo <= nxt_wbo;
        end
    end
endmodule

// File: rtl/mc_classify.sv
// Combinational decision for one access: result code and next state of
// both copies. Assumes the caller only applies the result when an access
// is valid. Index 0/1 of the arrays is the processor number.
module mc_classify
    import coh_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int IDXW = $clog2(WORDS)
) (
    input  logic             acc_cpu,
    input  logic             acc_write,
    input  logic [IDXW-1:0]  acc_word,
    input  line_st_t         st_i   [NCPU],
    input  logic [WORDS-1:0] wbo_i  [NCPU],
    output res_code_t        code,
    output line_st_t         st_o   [NCPU],
    output logic [WORDS-1:0] wbo_o  [NCPU]
);
    line_st_t         self_st, oth_st, n_self_st, n_oth_st;
    logic [WORDS-1:0] self_wbo, oth_wbo, n_self_wbo, n_oth_wbo, word_bit;
    res_code_t        miss_kind;

    // Select the issuing and the other copy.
    always_comb begin
        self_st  = acc_cpu ? st_i[1]  : st_i[0];
        oth_st   = acc_cpu ? st_i[0]  : st_i[1];
        self_wbo = acc_cpu ? wbo_i[1] : wbo_i[0];
        oth_wbo  = acc_cpu ? wbo_i[0] : wbo_i[1];
    end

    // Decide the result and the protocol transition.
    always_comb begin
        word_bit   = {{(WORDS-1){1'b0}}, 1'b1} << acc_word;
        miss_kind  = (|(self_wbo & word_bit)) ? RC_TRUE : RC_FALSE;
        n_self_st  = self_st;
        n_oth_st   = oth_st;
        n_self_wbo = self_wbo;
        n_oth_wbo  = oth_wbo;
        code       = RC_HIT;
        if (acc_write) begin
            case (self_st)
                ST_MOD:  code = RC_HIT;
                ST_SHR:  code = RC_TRUE;
                default: begin
                    code       = miss_kind;
                    n_self_wbo = '0;
                end
            endcase
            n_self_st = ST_MOD;
            n_oth_st  = ST_INV;
            n_oth_wbo = (oth_st == ST_INV) ? (oth_wbo | word_bit) : word_bit;
        end else if (self_st == ST_INV) begin
            code       = miss_kind;
            n_self_st  = ST_SHR;
            n_self_wbo = '0;
            if (oth_st == ST_MOD) n_oth_st = ST_SHR;
        end
    end

    // Map the issuing/other view back onto processor numbers.
    always_comb begin
        st_o[0]  = acc_cpu ? n_oth_st   : n_self_st;
        st_o[1]  = acc_cpu ? n_self_st  : n_oth_st;
        wbo_o[0] = acc_cpu ? n_oth_wbo  : n_self_wbo;
        wbo_o[1] = acc_cpu ? n_self_wbo : n_oth_wbo;
    end
endmodule

// File: rtl/coh_miss_classifier.sv
// Top: two cache copies of one block, a classifier, and a result register.
// Assumes WORDS >= 2 and at most one access per cycle.
module coh_miss_classifier
    import coh_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int IDXW = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_valid,
    input  logic            acc_cpu,
    input  logic            acc_write,
    input  logic [IDXW-1:0] acc_word,
    output logic            res_valid,
    output logic [1:0]      res_code
);
    line_st_t         st_q   [NCPU];
    logic [WORDS-1:0] wbo_q  [NCPU];
    line_st_t         st_n   [NCPU];
    logic [WORDS-1:0] wbo_n  [NCPU];
    res_code_t        code;

    for (genvar g = 0; g < NCPU; g++) begin : g_slot
        mc_line_slot #(.WORDS(WORDS)) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd     (acc_valid),
            .nxt_st  (st_n[g]),
            .nxt_wbo (wbo_n[g]),
            .st      (st_q[g]),
            .wbo     (wbo_q[g])
        );
    end

    mc_classify #(.WORDS(WORDS)) u_cls (
        .acc_cpu   (acc_cpu),
        .acc_write (acc_write),
        .acc_word  (acc_word),
        .st_i      (st_q),
        .wbo_i     (wbo_q),
        .code      (code),
        .st_o      (st_n),
        .wbo_o     (wbo_n)
    );

    // Register the result one cycle after the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_code  <= RC_HIT;
        end else begin
            res_valid <= acc_valid;
            if (acc_valid) res_code <= code;
        end
    end

    // R2: strobe follows the access by exactly one cycle.
    a_r2_strobe_on: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);
    a_r2_strobe_off: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);
    // R9: no illegal code is ever reported.
    a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_code != 2'b11);
    // R8: a Modified copy excludes a valid copy elsewhere.
    a_r8_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[0] == ST_MOD) |-> (st_q[1] == ST_INV));
    a_r8_single_owner_b: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q[1] == ST_MOD) |-> (st_q[0] == ST_INV));

    for (genvar g = 0; g < NCPU; g++) begin : g_chk
        // R9: idle cycles leave each copy untouched.
        a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !acc_valid |=> ($stable(st_q[g]) && $stable(wbo_q[g])));
        // R3: a read of a valid copy hits.
        a_r3_read_hit: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_cpu == g && !acc_write && st_q[g] != ST_INV)
            |=> res_code == RC_HIT);
        // R4: an owner write hits.
        a_r4_owner_hit: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_cpu == g && acc_write && st_q[g] == ST_MOD)
            |=> res_code == RC_HIT);
        // R5: an upgrade from Shared is a true sharing miss and takes ownership.
        a_r5_upgrade: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_cpu == g && acc_write && st_q[g] == ST_SHR)
            |=> (res_code == RC_TRUE && st_q[g] == ST_MOD));
        // R6: a read refetch leaves the reader Shared with an empty record.
        a_r6_refetch: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_cpu == g && !acc_write && st_q[g] == ST_INV)
            |=> (st_q[g] == ST_SHR && wbo_q[g] == '0 && res_code != RC_HIT));
        // R7: a write miss leaves the writer Modified with an empty record.
        a_r7_write_miss: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_valid && acc_cpu == g && acc_write && st_q[g] == ST_INV)
            |=> (st_q[g] == ST_MOD && wbo_q[g] == '0 && res_code != RC_HIT));
    end
endmodule

// File: tb/sim_coh_miss_classifier.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected codes, the monitor checks them.
module sim_coh_miss_classifier;
    localparam int WORDS = 4;
    localparam int IDXW  = $clog2(WORDS);
    localparam logic [1:0] HIT = 2'b00, TRU = 2'b01, FLS = 2'b10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 1'b0;
    logic            acc_cpu = 1'b0;
    logic            acc_write = 1'b0;
    logic [IDXW-1:0] acc_word = '0;
    logic            res_valid;
    logic [1:0]      res_code;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [1:0] exp_q [$];
    string      tag_q [$];

    always #10 clk = ~clk;

    coh_miss_classifier #(.WORDS(WORDS)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_cpu(acc_cpu),
        .acc_write(acc_write), .acc_word(acc_word),
        .res_valid(res_valid), .res_code(res_code)
    );

    // Present one access for one cycle and queue its expected code.
    task automatic access(input logic cpu, input logic wr, input int word,
                          input logic [1:0] exp, input string tag);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_cpu   = cpu;
        acc_write = wr;
        acc_word  = IDXW'(word);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare each result against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2 unexpected result: got %b expected none", res_code);
            end else begin
                automatic logic [1:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if (res_code !== e) begin
                    n_fail++;
                    $display("FAIL %s: got %b expected %b", t, res_code, e);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_run++;
        if (res_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1 reset strobe: got %b expected 0", res_valid);
        end
        // Words 0 and 1 play the two shared words; back to back throughout.
        access(0, 0, 0, HIT, "R1 P0 read w0 after reset");
        access(1, 0, 1, HIT, "R1 P1 read w1 after reset");
        access(0, 1, 0, TRU, "R5 P0 upgrade write w0");
        access(0, 1, 1, HIT, "R4 P0 owner write w1");
        access(1, 0, 2, FLS, "R6 P1 read unwritten w2");
        access(0, 0, 0, HIT, "R3 P0 read after downgrade");
        access(1, 1, 3, TRU, "R5 P1 upgrade write w3");
        access(0, 0, 1, FLS, "R6 P0 read w1 (only w3 written)");
        access(1, 1, 1, TRU, "R5 P1 upgrade write w1");
        @(negedge clk);
        acc_valid = 1'b0;
        @(negedge clk);
        // R9: idle cycles give no strobe.
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            n_run++;
            if (res_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R9 idle strobe: got %b expected 0", res_valid);
            end
        end
        access(0, 1, 1, TRU, "R7 P0 write miss on written w1");
        access(1, 1, 0, FLS, "R7 P1 write miss on unwritten w0");
        access(1, 0, 3, HIT, "R3 P1 owner read w3");
        access(0, 0, 0, TRU, "R6 P0 read written w0, owner downgraded");
        access(1, 0, 0, HIT, "R6 P1 still valid after downgrade");
        access(0, 1, 3, TRU, "R5 P0 upgrade on top word w3");
        access(1, 1, 3, TRU, "R7 P1 write miss on top word w3");
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (2) @(negedge clk);
        n_run++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing results: got %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule